// File: doc/BRIEF.md
# Cascaded Interrupt Vector Controller

The block joins two 8-input interrupt units into one 16-line controller. The primary unit serves lines 0 to 7. The secondary unit serves lines 8 to 15. The secondary's combined request takes the place of primary input 2, so a secondary line has to win its own unit first and then win again as line 2 at the primary. Each unit holds a 5-bit vector base, written through a simple register write port. While any serviceable request is pending and both bases are programmed, the primary asserts one interrupt output towards the processor.

The processor answers with two active-low acknowledge pulses. On the falling edge of the first pulse the controller freezes the winning line. During the second pulse it presents an 8-bit vector. The upper five bits of that vector are the winning unit's base and the lower three bits are the line's code within that unit. When the cascaded input wins at the primary, the vector is built from the secondary's base and the secondary's line code. When the second pulse ends, the serviced request is dropped.

Top module: `cic_top`

## Requirements
- R1: A write with address 8'h21 loads the primary base from wr_data[7:3], and a write with address 8'hA1 loads the secondary base from wr_data[7:3]. wr_data[2:0] is ignored, and a write to any other address changes neither base.
- R2: intr stays low until both bases have been written at least once since reset, even if requests are pending.
- R3: intr is high exactly when the controller is not inside an acknowledge handshake, both bases are programmed, and at least one serviceable request is pending. It goes low from the first acknowledge pulse until the handshake ends.
- R4: Priority is fixed, and the lowest line wins inside each unit. At the primary, the cascaded input (line 2) ranks below lines 0 and 1 and above lines 3 to 7, so the overall order is 0, 1, 8–15, 3–7.
- R5: The vector is {base[4:0], code[2:0]}. On a primary win the code is the line number 0–7. On a cascaded win the vector uses the secondary base, and the code is the line number minus 8.
- R6: vec_valid is high only from the clock after the second acknowledge falling edge until the clock after that pulse rises. While vec_valid is low, vec_data is 8'h00.
- R7: The winner is frozen at the first acknowledge falling edge. A request raised between the two pulses does not change the vector returned.
- R8: When the second pulse ends, the serviced line's pending bit is cleared. Other pending lines stay pending and are served by later handshakes.
- R9: irq_req[2] is ignored, because primary input 2 is taken by the cascade. A request on that pin alone never raises intr.
- R10: A request held high for a single clock is latched and stays pending until it is serviced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address (8'h21 primary, 8'hA1 secondary) |
| wr_data | input | 8 | Write data; bits [7:3] form the base |
| irq_req | input | 16 | Request lines 0–15 (line 2 unused) |
| inta_n | input | 1 | Active-low acknowledge pulses from the processor |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector is being presented |
| vec_data | output | 8 | Interrupt vector |

## Verification
The assertions assume that inta_n is synchronous to clk and comes only as well-formed pairs of pulses, each pulse at least one clock low and one clock high. They also assume that a handshake is started only while intr is high. The stimulus drives every input on the falling clock edge. It opens an acknowledge only after requests have been latched with both bases programmed, and it holds each pulse level for at least one full clock. The one exception is a request injected during the high gap between the two pulses, which exercises the freeze.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int UNIT_LINES = 8;
    localparam int CODE_W     = $clog2(UNIT_LINES);
    localparam int BASE_W     = 5;
    localparam int VEC_W      = BASE_W + CODE_W;
    localparam int NUM_UNITS  = 2;
    localparam int ALL_LINES  = UNIT_LINES * NUM_UNITS;
    localparam int LINE_W     = $clog2(ALL_LINES);

    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_FIRST  = 2'd1,
        HS_GAP    = 2'd2,
        HS_SECOND = 2'd3
    } hs_state_e;
endpackage

// File: rtl/cic_arbiter.sv
module cic_arbiter #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/cic_cfg_regs.sv
module cic_cfg_regs #(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 8,
    parameter int              BASE_W   = 5,
    parameter logic [ADDR_W-1:0] PRI_ADDR = 8'h21,
    parameter logic [ADDR_W-1:0] SEC_ADDR = 8'hA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [BASE_W-1:0] pri_base,
    output logic [BASE_W-1:0] sec_base,
    output logic              cfg_ready
);
    typedef struct packed {
        logic [BASE_W-1:0] pbase;
        logic [BASE_W-1:0] sbase;
        logic              pset;
        logic              sset;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [BASE_W-1:0] wr_base;

    always_comb begin
        wr_base = wr_data[DATA_W-1 -: BASE_W];
        cfg_d   = cfg_q;
        if (wr_en && wr_addr == PRI_ADDR) begin
            cfg_d.pbase = wr_base;
            cfg_d.pset  = 1'b1;
        end
        if (wr_en && wr_addr == SEC_ADDR) begin
            cfg_d.sbase = wr_base;
            cfg_d.sset  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign pri_base  = cfg_q.pbase;
    assign sec_base  = cfg_q.sbase;
    assign cfg_ready = cfg_q.pset & cfg_q.sset;

    assert_ready_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_ready) |-> $past(wr_en));
    assert_pbase_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pri_base) |-> $past(wr_en && wr_addr == PRI_ADDR));
    assert_sbase_by_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_base) |-> $past(wr_en && wr_addr == SEC_ADDR));
endmodule

// File: rtl/cic_ack_fsm.sv
module cic_ack_fsm
    import cic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inta_n,
    input  logic req_any,
    output logic freeze,
    output logic release_line,
    output logic busy,
    output logic vec_valid
);
    typedef struct packed {
        hs_state_e st;
        logic      inta_prev;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic fall, rise;

    always_comb begin
        fall         = fsm_q.inta_prev & ~inta_n;
        rise         = ~fsm_q.inta_prev & inta_n;
        fsm_d        = fsm_q;
        fsm_d.inta_prev = inta_n;
        freeze       = 1'b0;
        release_line = 1'b0;
        unique case (fsm_q.st)
            HS_IDLE: if (fall && req_any) begin
                freeze   = 1'b1;
                fsm_d.st = HS_FIRST;
            end
            HS_FIRST:  if (rise) fsm_d.st = HS_GAP;
            HS_GAP:    if (fall) fsm_d.st = HS_SECOND;
            HS_SECOND: if (rise) begin
                release_line = 1'b1;
                fsm_d.st     = HS_IDLE;
            end
            default:   fsm_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{st: HS_IDLE, inta_prev: 1'b1};
        else        fsm_q <= fsm_d;
    end

    assign busy      = (fsm_q.st != HS_IDLE);
    assign vec_valid = (fsm_q.st == HS_SECOND);

    assert_valid_after_low_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> !$past(inta_n));
    assert_release_ends_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        release_line |=> !vec_valid);
endmodule

// File: rtl/cic_top.sv
module cic_top
    import cic_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] PRI_ADDR = 8'hA1 ^ 8'h80,
    parameter logic [ADDR_W-1:0] SEC_ADDR = 8'hA1,
    parameter int                CASC_IN  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ALL_LINES-1:0] irq_req,
    input  logic                 inta_n,
    output logic                 intr,
    output logic                 vec_valid,
    output logic [VEC_W-1:0]     vec_data
);
    localparam logic [ALL_LINES-1:0] LINE_MASK = ~(ALL_LINES'(1) << CASC_IN);

    typedef struct packed {
        logic [ALL_LINES-1:0] pend;
        logic [VEC_W-1:0]     vec;
        logic [LINE_W-1:0]    clr;
    } core_t;

    core_t core_d, core_q;

    logic [BASE_W-1:0]     pri_base, sec_base;
    logic                  cfg_ready;
    logic [UNIT_LINES-1:0] unit_req [NUM_UNITS];
    logic                  unit_hit [NUM_UNITS];
    logic [CODE_W-1:0]     unit_idx [NUM_UNITS];
    logic                  cascaded, freeze, release_line, busy, req_any;
    logic [VEC_W-1:0]      win_vec;
    logic [LINE_W-1:0]     win_line;

    cic_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_W(BASE_W),
        .PRI_ADDR(PRI_ADDR), .SEC_ADDR(SEC_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pri_base(pri_base), .sec_base(sec_base),
        .cfg_ready(cfg_ready)
    );

    // unit 0 = primary, unit 1 = secondary
    always_comb begin
        unit_req[1]          = core_q.pend[ALL_LINES-1 -: UNIT_LINES];
        unit_req[0]          = core_q.pend[UNIT_LINES-1:0];
        unit_req[0][CASC_IN] = unit_hit[1];
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        cic_arbiter #(.N(UNIT_LINES), .IW(CODE_W)) u_arb (
            .req(unit_req[u]), .hit(unit_hit[u]), .idx(unit_idx[u])
        );
    end

    assign req_any = cfg_ready & unit_hit[0];

    cic_ack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .inta_n(inta_n), .req_any(req_any),
        .freeze(freeze), .release_line(release_line), .busy(busy),
        .vec_valid(vec_valid)
    );

    always_comb begin
        cascaded = unit_hit[0] && (unit_idx[0] == CODE_W'(CASC_IN));
        if (cascaded) begin
            win_vec  = {sec_base, unit_idx[1]};
            win_line = {1'b1, unit_idx[1]};
        end else begin
            win_vec  = {pri_base, unit_idx[0]};
            win_line = {1'b0, unit_idx[0]};
        end

        core_d      = core_q;
        core_d.pend = core_q.pend | (irq_req & LINE_MASK);
        if (freeze) begin
            core_d.vec = win_vec;
            core_d.clr = win_line;
        end
        if (release_line) core_d.pend[core_q.clr] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign intr     = req_any & ~busy;
    assign vec_data = vec_valid ? core_q.vec : '0;

    assert_pri_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unit_hit[0] |-> (unit_req[0][unit_idx[0]] &&
            ((unit_req[0] & ((UNIT_LINES'(1) << unit_idx[0]) - UNIT_LINES'(1))) == '0)));
    assert_sec_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unit_hit[1] |-> (unit_req[1][unit_idx[1]] &&
            ((unit_req[1] & ((UNIT_LINES'(1) << unit_idx[1]) - UNIT_LINES'(1))) == '0)));
    assert_vector_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid)) |-> $stable(vec_data));
    assert_served_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_line |=> !core_q.pend[$past(core_q.clr)]);
    assert_quiet_in_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !intr);
endmodule

// File: tb/cic_top_bench.sv
module cic_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] irq_req = '0;
    logic        inta_n = 1'b1;
    logic        intr, vec_valid;
    logic [7:0]  vec_data;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cic_top u_cic_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_req(irq_req), .inta_n(inta_n),
        .intr(intr), .vec_valid(vec_valid), .vec_data(vec_data)
    );

    // ---------------- behavioural reference model ----------------
    int          rank [15] = '{0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7};
    int          m_phase;
    bit          m_prev;
    bit [15:0]   m_pend;
    int          m_pbase, m_sbase;
    bit          m_pok, m_sok;
    int          m_vec, m_clr;

    function automatic int m_winner();
        foreach (rank[k]) if (m_pend[rank[k]]) return rank[k];
        return -1;
    endfunction

    function automatic int m_vector(int line);
        if (line < 8) return (m_pbase * 8) + line;
        return (m_sbase * 8) + (line - 8);
    endfunction

    function automatic bit m_intr();
        return (m_phase == 0) && m_pok && m_sok && (m_winner() >= 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_prev = 1; m_pend = '0;
            m_pbase = 0; m_sbase = 0; m_pok = 0; m_sok = 0;
            m_vec = 0; m_clr = 0;
        end else begin
            bit fall, rise, drop;
            int w;
            fall = m_prev && !inta_n;
            rise = !m_prev && inta_n;
            drop = 0;
            w = m_winner();
            case (m_phase)
                0: if (fall && m_pok && m_sok && w >= 0) begin
                       m_vec = m_vector(w); m_clr = w; m_phase = 1;
                   end
                1: if (rise) m_phase = 2;
                2: if (fall) m_phase = 3;
                default: if (rise) begin m_phase = 0; drop = 1; end
            endcase
            for (int i = 0; i < 16; i++) if (i != 2 && irq_req[i]) m_pend[i] = 1;
            if (drop) m_pend[m_clr] = 0;
            if (wr_en && wr_addr == 8'h21) begin m_pbase = wr_data / 8; m_pok = 1; end
            if (wr_en && wr_addr == 8'hA1) begin m_sbase = wr_data / 8; m_sok = 1; end
            m_prev = inta_n;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ev;
            ev = (m_phase == 3) ? m_vec : 0;
            nchk++;
            if (intr !== m_intr()) begin
                nfail++;
                $display("FAIL R3 intr: actual %0b expected %0b", intr, m_intr());
            end
            nchk++;
            if (vec_valid !== (m_phase == 3)) begin
                nfail++;
                $display("FAIL R6 vec_valid: actual %0b expected %0b", vec_valid, m_phase == 3);
            end
            nchk++;
            if (vec_data !== 8'(ev)) begin
                nfail++;
                $display("FAIL R5 vec_data: actual %02h expected %02h", vec_data, ev);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk); irq_req = m;
        @(negedge clk); irq_req = '0;
    endtask

    task automatic ack(input logic [7:0] exp, input string tag, input logic [15:0] mid);
        @(negedge clk); inta_n = 0;
        @(negedge clk);
        chk({tag, " R6 no vector in first pulse"}, 32'(vec_valid), 0);
        chk({tag, " R3 intr low in handshake"}, 32'(intr), 0);
        inta_n = 1; irq_req = mid;
        @(negedge clk); irq_req = '0; inta_n = 0;
        @(negedge clk);
        chk({tag, " R6 valid in second pulse"}, 32'(vec_valid), 1);
        chk({tag, " vector"}, 32'(vec_data), 32'(exp));
        inta_n = 1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset intr", 32'(intr), 0);
        chk("R6 reset valid", 32'(vec_valid), 0);
        chk("R6 reset data", 32'(vec_data), 0);

        pulse(16'h0020);
        @(negedge clk);
        chk("R2 unprogrammed intr", 32'(intr), 0);
        wr(8'h21, 8'h0F);
        @(negedge clk);
        chk("R2 only primary programmed", 32'(intr), 0);
        wr(8'h20, 8'hF8);
        wr(8'hA1, 8'h70);
        @(negedge clk);
        chk("R10 latched single-cycle pulse", 32'(intr), 1);
        ack(8'h0D, "R1 R5 low bits and stray write ignored", 16'h0);
        chk("R8 drained", 32'(intr), 0);

        pulse(16'h004A);
        ack(8'h09, "R4 line1 first", 16'h0);
        ack(8'h0B, "R4 line3 second", 16'h0);
        ack(8'h0E, "R8 line6 last", 16'h0);
        chk("R8 all served", 32'(intr), 0);

        pulse(16'h1010);
        ack(8'h74, "R5 cascade beats line4", 16'h0);
        ack(8'h0C, "R4 line4 after cascade", 16'h0);

        pulse(16'h0401);
        ack(8'h08, "R4 line0 beats cascade", 16'h0);
        ack(8'h72, "R5 secondary line10", 16'h0);

        pulse(16'h8200);
        ack(8'h71, "R4 secondary line9 first", 16'h0);
        ack(8'h77, "R4 secondary line15", 16'h0);

        pulse(16'h0020);
        ack(8'h0D, "R7 frozen despite line0 in gap", 16'h0001);
        ack(8'h08, "R7 late line0 served next", 16'h0);

        pulse(16'h0004);
        repeat (3) @(negedge clk);
        chk("R9 line2 pin ignored", 32'(intr), 0);

        wr(8'h21, 8'h20);
        pulse(16'h0080);
        ack(8'h27, "R1 reprogrammed base", 16'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule